// File: doc/BRIEF.md
# DRAM Bring-Up Command Sequencer

This block walks a DRAM interface through its power-up steps from the controller side. A one-cycle `start` pulse begins the run. The sequencer first gates the DRAM clock output. It then drives the external reset line through two timed phases, whose order depends on the chip revision. Next it applies the configuration, turns the clock output back on and loads the CKE delay count. After that it runs the initialization handshake twice, with a mode-register load between the two. When the run is a resume from standby, it releases the pad hold and issues a self-refresh exit. Every run ends with one refresh command.

Each handshake step issues a one-cycle write strobe and then waits for a self-clearing busy bit that a modelled controller returns. Every such wait carries its own deadline, counted in microsecond ticks. The tick counter restarts each time a state is entered. If the deadline expires, the sequencer stops and reports which wait stalled. The chip revision and the resume flag are latched when `start` is accepted.

States: IDLE, CLK_OFF, RST_A (first reset level), RST_B (second reset level), CFG, CLK_ON, CKE, INIT1_GO, INIT1_WAIT, MR, INIT2_GO, INIT2_WAIT, PAD_GO, PAD_WAIT, SRX_GO, SRX_WAIT, REF_GO, REF_WAIT, DONE, FAIL. Each state moves to the next one in this list, with these exceptions:
- IDLE, DONE and FAIL move to CLK_OFF on `start`.
- RST_A and RST_B each advance when their tick count expires.
- Each WAIT state advances when its busy input reads low, and moves to FAIL when its deadline expires.
- INIT2_WAIT moves to PAD_GO when the latched resume flag is set, and to REF_GO otherwise.
- REF_WAIT moves to DONE.

Top module: `dram_bringup_seq`

## Requirements
- R1: After reset all strobes, `done`, `timeout`, `dclk_en` and `err_code` are 0 and `dram_rst` is 1. `start` is accepted only in IDLE, DONE or FAIL, and a `start` pulse during a run changes nothing.
- R2: With `chip_rev` = 0 the reset line is driven low and then high. With any other revision it is driven high and then low. Each level is held for exactly RST_US ticks.
- R3: `dclk_en` is 0 from the cycle after `start` up to and including the configuration strobe. It is 1 from clock-on through DONE, and 0 in FAIL.
- R4: `cke_wr` pulses once, after clock-on and before the first init, with `cke_val` = 0x1FFFF.
- R5: `init_wr` is issued twice, before and after `mr_wr`. No later strobe is issued while `init_busy` is high.
- R6: Strobes come in the order: config, CKE, init, mode-register, init. When resume is set, these follow: pad release, wait for `pad_busy` low, then `cmd_wr` with code 0x12, wait for `cmd_busy` low. Without resume these two steps are skipped.
- R7: The run ends with `cmd_wr` carrying code 0x13. After `cmd_busy` reads low, `done` rises and stays high until the next `start`.
- R8: A wait fails on the TMO_US-th tick counted after its entry if its busy bit is still set. The tick count restarts at every state entry.
- R9: On failure `timeout` stays high, no further strobes are issued, and `err_code` holds the stalled wait: 1 for the first init, 2 for the second init, 3 for the pad release, 4 for the self-refresh exit, 5 for the refresh.
- R10: When a busy bit reads low in the same cycle as the deadline tick, the step completes and no timeout is taken.
- R11: At most one strobe is high in any cycle, and `cmd_code` is 0 whenever `cmd_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a bring-up run |
| resume | input | 1 | Run is a resume from standby (latched at start) |
| chip_rev | input | 2 | Chip revision; selects the reset pulse polarity (latched at start) |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| init_busy | input | 1 | Initialization bit read back from the controller |
| pad_busy | input | 1 | Pad power-control bit 0 read back |
| cmd_busy | input | 1 | Command-field busy bit (bit 31) read back |
| dram_rst | output | 1 | External DRAM reset line level |
| dclk_en | output | 1 | DRAM clock output enable |
| cfg_wr | output | 1 | Strobe: apply configuration |
| cke_wr | output | 1 | Strobe: load the CKE delay count |
| cke_val | output | 17 | CKE delay count |
| init_wr | output | 1 | Strobe: set the initialization bit |
| mr_wr | output | 1 | Strobe: load the mode registers |
| pad_rel_wr | output | 1 | Strobe: release the pad hold |
| cmd_wr | output | 1 | Strobe: write the command field |
| cmd_code | output | 5 | Command code for the field at bits 31:27 |
| done | output | 1 | Run completed |
| timeout | output | 1 | A wait exceeded its deadline |
| err_code | output | 3 | Identifies the wait that stalled |

## Verification
The functions that can fall in the same cycle are step completion and deadline expiry. A wait that sees its busy bit clear can also be on the very tick that ends its deadline. The controller model in the bench tracks the ticks seen during the first init wait. It predicts the next tick and drops `init_busy` exactly as that wait's last allowed tick arrives. The run is judged correct when it reaches `done` with `timeout` low and the full strobe order intact. A second overlap, a `start` pulse landing mid-run, is provoked in random runs and judged by an unchanged strobe order.

// File: rtl/dseq_pkg.sv
`timescale 1ns/1ps
package dseq_pkg;

    localparam int unsigned CMD_W = 5;
    localparam int unsigned ERR_W = 3;

    localparam logic [CMD_W-1:0] CMD_SELF_REFRESH_EXIT = 5'h12;
    localparam logic [CMD_W-1:0] CMD_REFRESH           = 5'h13;

    typedef enum logic [4:0] {
        S_IDLE,
        S_CLK_OFF,
        S_RST_A,
        S_RST_B,
        S_CFG,
        S_CLK_ON,
        S_CKE,
        S_INIT1_GO,
        S_INIT1_WAIT,
        S_MR,
        S_INIT2_GO,
        S_INIT2_WAIT,
        S_PAD_GO,
        S_PAD_WAIT,
        S_SRX_GO,
        S_SRX_WAIT,
        S_REF_GO,
        S_REF_WAIT,
        S_DONE,
        S_FAIL
    } seq_state_e;

    // Identifies which wait stalled; 0 means no stall.
    function automatic logic [ERR_W-1:0] stall_code(input seq_state_e s);
        case (s)
            S_INIT1_WAIT: stall_code = 3'd1;
            S_INIT2_WAIT: stall_code = 3'd2;
            S_PAD_WAIT:   stall_code = 3'd3;
            S_SRX_WAIT:   stall_code = 3'd4;
            S_REF_WAIT:   stall_code = 3'd5;
            default:      stall_code = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dseq_deadline.sv
`timescale 1ns/1ps
module dseq_deadline #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter,
    input  logic             timed,
    input  logic             us_tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Tick count since the current state was entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (enter) begin
            cnt_q <= '0;
        end else if (timed && us_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = timed && us_tick && (cnt_q == limit - 1'b1);

    // R8: inside a timed state the count never reaches its limit
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timed |-> (cnt_q < limit));

endmodule

// File: rtl/dseq_outdec.sv
`timescale 1ns/1ps
module dseq_outdec
    import dseq_pkg::*;
(
    input  seq_state_e       state,
    input  logic             rst_first,
    output logic             dram_rst,
    output logic             dclk_en,
    output logic             cfg_wr,
    output logic             cke_wr,
    output logic             init_wr,
    output logic             mr_wr,
    output logic             pad_rel_wr,
    output logic             cmd_wr,
    output logic [CMD_W-1:0] cmd_code,
    output logic             done,
    output logic             timeout
);

    always_comb begin
        dram_rst   = ~rst_first;
        dclk_en    = 1'b1;
        cfg_wr     = 1'b0;
        cke_wr     = 1'b0;
        init_wr    = 1'b0;
        mr_wr      = 1'b0;
        pad_rel_wr = 1'b0;
        cmd_wr     = 1'b0;
        cmd_code   = '0;
        done       = 1'b0;
        timeout    = 1'b0;
        unique case (state)
            S_IDLE, S_CLK_OFF, S_RST_B: dclk_en = 1'b0;
            S_RST_A: begin
                dclk_en  = 1'b0;
                dram_rst = rst_first;
            end
            S_CFG: begin
                dclk_en = 1'b0;
                cfg_wr  = 1'b1;
            end
            S_CKE:                    cke_wr     = 1'b1;
            S_INIT1_GO, S_INIT2_GO:   init_wr    = 1'b1;
            S_MR:                     mr_wr      = 1'b1;
            S_PAD_GO:                 pad_rel_wr = 1'b1;
            S_SRX_GO: begin
                cmd_wr   = 1'b1;
                cmd_code = CMD_SELF_REFRESH_EXIT;
            end
            S_REF_GO: begin
                cmd_wr   = 1'b1;
                cmd_code = CMD_REFRESH;
            end
            S_DONE: done = 1'b1;
            S_FAIL: begin
                dclk_en = 1'b0;
                timeout = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dram_bringup_seq.sv
`timescale 1ns/1ps
module dram_bringup_seq
    import dseq_pkg::*;
#(
    parameter int unsigned TMO_US  = 1000000,
    parameter int unsigned RST_US  = 2,
    parameter int unsigned CKE_W   = 17,
    parameter int unsigned CKE_DLY = 'h1FFFF,
    parameter int unsigned REV_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             resume,
    input  logic [REV_W-1:0] chip_rev,
    input  logic             us_tick,
    input  logic             init_busy,
    input  logic             pad_busy,
    input  logic             cmd_busy,
    output logic             dram_rst,
    output logic             dclk_en,
    output logic             cfg_wr,
    output logic             cke_wr,
    output logic [CKE_W-1:0] cke_val,
    output logic             init_wr,
    output logic             mr_wr,
    output logic             pad_rel_wr,
    output logic             cmd_wr,
    output logic [CMD_W-1:0] cmd_code,
    output logic             done,
    output logic             timeout,
    output logic [ERR_W-1:0] err_code
);

    localparam int unsigned MAX_US = (TMO_US > RST_US) ? TMO_US : RST_US;
    localparam int unsigned CNT_W  = $clog2(MAX_US + 1);

    seq_state_e       state_q, state_n;
    logic             rst_first_q;
    logic             resume_q;
    logic [ERR_W-1:0] err_q;
    logic             accept;
    logic             enter;
    logic             timed;
    logic             expire;
    logic [CNT_W-1:0] limit;

    assign accept = start && (state_q inside {S_IDLE, S_DONE, S_FAIL});
    assign enter  = (state_n != state_q);
    assign timed  = state_q inside {S_RST_A, S_RST_B, S_INIT1_WAIT, S_INIT2_WAIT,
                                    S_PAD_WAIT, S_SRX_WAIT, S_REF_WAIT};
    assign limit  = (state_q inside {S_RST_A, S_RST_B}) ? CNT_W'(RST_US) : CNT_W'(TMO_US);

    dseq_deadline #(.CNT_W(CNT_W)) u_deadline (
        .clk     (clk),
        .rst_n   (rst_n),
        .enter   (enter),
        .timed   (timed),
        .us_tick (us_tick),
        .limit   (limit),
        .expire  (expire)
    );

    // Next-state selection; completion is tested before the deadline.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE, S_DONE, S_FAIL: if (start) state_n = S_CLK_OFF;
            S_CLK_OFF:   state_n = S_RST_A;
            S_RST_A:     if (expire) state_n = S_RST_B;
            S_RST_B:     if (expire) state_n = S_CFG;
            S_CFG:       state_n = S_CLK_ON;
            S_CLK_ON:    state_n = S_CKE;
            S_CKE:       state_n = S_INIT1_GO;
            S_INIT1_GO:  state_n = S_INIT1_WAIT;
            S_INIT1_WAIT: begin
                if (!init_busy)  state_n = S_MR;
                else if (expire) state_n = S_FAIL;
            end
            S_MR:        state_n = S_INIT2_GO;
            S_INIT2_GO:  state_n = S_INIT2_WAIT;
            S_INIT2_WAIT: begin
                if (!init_busy)  state_n = resume_q ? S_PAD_GO : S_REF_GO;
                else if (expire) state_n = S_FAIL;
            end
            S_PAD_GO:    state_n = S_PAD_WAIT;
            S_PAD_WAIT: begin
                if (!pad_busy)   state_n = S_SRX_GO;
                else if (expire) state_n = S_FAIL;
            end
            S_SRX_GO:    state_n = S_SRX_WAIT;
            S_SRX_WAIT: begin
                if (!cmd_busy)   state_n = S_REF_GO;
                else if (expire) state_n = S_FAIL;
            end
            S_REF_GO:    state_n = S_REF_WAIT;
            S_REF_WAIT: begin
                if (!cmd_busy)   state_n = S_DONE;
                else if (expire) state_n = S_FAIL;
            end
            default:     state_n = S_IDLE;
        endcase
    end

    // State register and run-scoped latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            rst_first_q <= 1'b0;
            resume_q    <= 1'b0;
            err_q       <= '0;
        end else begin
            state_q <= state_n;
            if (accept) begin
                rst_first_q <= (chip_rev != '0);
                resume_q    <= resume;
                err_q       <= '0;
            end else if (state_n == S_FAIL && state_q != S_FAIL) begin
                err_q <= stall_code(state_q);
            end
        end
    end

    dseq_outdec u_outdec (
        .state      (state_q),
        .rst_first  (rst_first_q),
        .dram_rst   (dram_rst),
        .dclk_en    (dclk_en),
        .cfg_wr     (cfg_wr),
        .cke_wr     (cke_wr),
        .init_wr    (init_wr),
        .mr_wr      (mr_wr),
        .pad_rel_wr (pad_rel_wr),
        .cmd_wr     (cmd_wr),
        .cmd_code   (cmd_code),
        .done       (done),
        .timeout    (timeout)
    );

    assign cke_val  = CKE_W'(CKE_DLY);
    assign err_code = err_q;

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cfg_wr, cke_wr, init_wr, mr_wr, pad_rel_wr, cmd_wr}) <= 1);

    assert_cmd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |-> (cmd_code == '0));

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_fail_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !start) |=> (timeout && $stable(err_code)));

    assert_clk_gated_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> !dclk_en);

    assert_mr_after_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mr_wr |-> $past(!init_busy));

endmodule

// File: tb/sim_dram_bringup_seq.sv
`timescale 1ns/1ps
module sim_dram_bringup_seq;

    localparam int TMO = 12;
    localparam int RSTU = 3;
    localparam int DIV = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       resume = 1'b0;
    logic [1:0] chip_rev = 2'd0;
    logic       us_tick = 1'b0;
    logic       init_busy = 1'b0, pad_busy = 1'b0, cmd_busy = 1'b0;
    logic       dram_rst, dclk_en, cfg_wr, cke_wr, init_wr, mr_wr, pad_rel_wr, cmd_wr;
    logic [16:0] cke_val;
    logic [4:0] cmd_code;
    logic       done, timeout;
    logic [2:0] err_code;

    dram_bringup_seq #(.TMO_US(TMO), .RST_US(RSTU)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .chip_rev(chip_rev),
        .us_tick(us_tick), .init_busy(init_busy), .pad_busy(pad_busy), .cmd_busy(cmd_busy),
        .dram_rst(dram_rst), .dclk_en(dclk_en), .cfg_wr(cfg_wr), .cke_wr(cke_wr),
        .cke_val(cke_val), .init_wr(init_wr), .mr_wr(mr_wr), .pad_rel_wr(pad_rel_wr),
        .cmd_wr(cmd_wr), .cmd_code(cmd_code), .done(done), .timeout(timeout),
        .err_code(err_code)
    );

    int  n_run = 0;
    int  n_fail = 0;
    bit  fin = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Controller model and tick generator.
    int tdiv = 0;
    int hold = 0;
    int stall_sel = 0;
    bit race_mode = 1'b0;
    bit mdl_clr = 1'b0;
    int init_seen = 0;
    int init_left = 0, pad_left = 0, cmd_left = 0;
    int init_ticks = 0;
    bit init_stall = 1'b0, pad_stall = 1'b0, cmd_stall = 1'b0;

    always @(posedge clk) begin
        int nd;
        bit nt;
        int tk;
        int code;
        nd = (tdiv == DIV - 1) ? 0 : tdiv + 1;
        nt = (nd == DIV - 1);
        tdiv <= nd;
        us_tick <= nt;
        if (!rst_n || mdl_clr) begin
            init_busy <= 1'b0;
            pad_busy  <= 1'b0;
            cmd_busy  <= 1'b0;
            init_seen <= 0;
        end else begin
            if (init_wr) begin
                init_busy  <= 1'b1;
                init_left  <= hold;
                init_ticks <= 0;
                init_stall <= (stall_sel == init_seen + 1);
                init_seen  <= init_seen + 1;
            end else if (init_busy) begin
                tk = init_ticks + (us_tick ? 1 : 0);
                init_ticks <= tk;
                if (init_stall) begin
                    if (race_mode && nt && tk == TMO - 1) init_busy <= 1'b0;
                end else if (init_left == 0) init_busy <= 1'b0;
                else init_left <= init_left - 1;
            end
            if (pad_rel_wr) begin
                pad_busy  <= 1'b1;
                pad_left  <= hold;
                pad_stall <= (stall_sel == 3);
            end else if (pad_busy && !pad_stall) begin
                if (pad_left == 0) pad_busy <= 1'b0;
                else pad_left <= pad_left - 1;
            end
            if (cmd_wr) begin
                code = (cmd_code == 5'h12) ? 4 : 5;
                cmd_busy  <= 1'b1;
                cmd_left  <= hold;
                cmd_stall <= (stall_sel == code);
            end else if (cmd_busy && !cmd_stall) begin
                if (cmd_left == 0) cmd_busy <= 1'b0;
                else cmd_left <= cmd_left - 1;
            end
        end
    end

    // Expected strobe codes: 1 cfg, 2 cke, 3 init, 4 mode reg, 6 pad, 7 cmd 0x12, 8 cmd 0x13.
    function automatic int exp_ev(input int i, input bit res);
        case (i)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 3;
            5: return res ? 6 : 8;
            6: return res ? 7 : 0;
            7: return res ? 8 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int stall_pos(input int stl, input bit res);
        case (stl)
            1: return 2;
            2: return 4;
            3: return 5;
            4: return 6;
            default: return res ? 7 : 5;
        endcase
    endfunction

    task automatic run_seq(input bit res, input int rev, input int stl, input bit race,
                           input bit mid, input int hld);
        int ev[16];
        int nev = 0, ph = 0, t1 = 0, t2 = 0, cyc = 0, tc = 0;
        int viol = 0, cmdbad = 0, ckebad = 0, clkon_bad = 0, quiet_bad = 0;
        int dclk_cke = -1, exp_n, mism = 0, spos, code;
        bit cfg_seen = 1'b0, clk_bad = 1'b0, tc_on = 1'b0, first_lvl;
        bit any_wr;
        first_lvl = (rev != 0);
        spos = stall_pos(stl, res);
        exp_n = (stl != 0 && !race) ? spos + 1 : (res ? 8 : 6);
        @(negedge clk);
        hold = hld; stall_sel = stl; race_mode = race; mdl_clr = 1'b1;
        resume = res; chip_rev = rev[1:0];
        @(negedge clk);
        mdl_clr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (cyc < 3000) begin
            start = (mid && cyc == 6);
            if (tc_on && !timeout) tc += us_tick;
            if (!cfg_seen) begin
                if (dclk_en) clk_bad = 1'b1;
                if (ph == 0 && dram_rst == first_lvl) ph = 1;
                if (ph == 1) begin
                    if (dram_rst == first_lvl) t1 += us_tick;
                    else ph = 2;
                end
                if (ph == 2 && !cfg_wr) t2 += us_tick;
            end
            any_wr = cfg_wr | cke_wr | init_wr | mr_wr | pad_rel_wr | cmd_wr;
            if (any_wr && (init_busy | pad_busy | cmd_busy)) viol++;
            if (any_wr && !cfg_wr && !dclk_en) clkon_bad++;
            if (!cmd_wr && cmd_code != 5'd0) cmdbad++;
            code = 0;
            if (cfg_wr) begin code = 1; cfg_seen = 1'b1; end
            if (cke_wr) begin
                code = 2; dclk_cke = dclk_en;
                if (cke_val != 17'h1FFFF) ckebad++;
            end
            if (init_wr) code = 3;
            if (mr_wr) code = 4;
            if (pad_rel_wr) code = 6;
            if (cmd_wr) code = (cmd_code == 5'h12) ? 7 : (cmd_code == 5'h13) ? 8 : 9;
            if (code != 0) begin
                if (nev < 16) ev[nev] = code;
                if (stl != 0 && nev == spos) tc_on = 1'b1;
                nev++;
            end
            if (done || timeout) break;
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(nev == exp_n, "R5 strobe count", nev, exp_n);
        for (int i = 0; i < 16; i++)
            if (i < nev && i < exp_n && ev[i] != exp_ev(i, res)) mism++;
        chk(mism == 0, "R6 strobe order", mism, 0);
        chk(ph == 2, "R2 reset order", ph, 2);
        chk(t1 == RSTU, "R2 first reset level ticks", t1, RSTU);
        chk(t2 == RSTU, "R2 second reset level ticks", t2, RSTU);
        chk(!clk_bad, "R3 clock gated until config", clk_bad, 0);
        chk(clkon_bad == 0, "R3 clock on after config", clkon_bad, 0);
        chk(dclk_cke == 1, "R4 clock on at CKE load", dclk_cke, 1);
        chk(ckebad == 0, "R4 CKE delay value", ckebad, 0);
        chk(viol == 0, "R5 strobe while busy", viol, 0);
        chk(cmdbad == 0, "R11 command code idle", cmdbad, 0);
        if (stl != 0 && !race) begin
            chk(timeout == 1'b1, "R9 timeout flag", timeout, 1);
            chk(int'(err_code) == stl, "R9 stall code", err_code, stl);
            chk(tc == TMO, "R8 deadline ticks", tc, TMO);
            chk(dclk_en == 1'b0, "R3 clock off in FAIL", dclk_en, 0);
        end else begin
            chk(done == 1'b1, race ? "R10 completion beats deadline" : "R7 done", done, 1);
            chk(timeout == 1'b0, "R10 no timeout on completion", timeout, 0);
        end
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (cfg_wr | cke_wr | init_wr | mr_wr | pad_rel_wr | cmd_wr) quiet_bad++;
            if ((stl != 0 && !race) ? !timeout : !done) quiet_bad++;
        end
        if (stl != 0 && !race) chk(quiet_bad == 0, "R9 quiet and held after timeout", quiet_bad, 0);
        else chk(quiet_bad == 0, "R7 done held and quiet", quiet_bad, 0);
    endtask

    initial begin
        int r, rv, st, h, m, k;
        void'($urandom(32'h5eed_0101));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !timeout, "R1 flags after reset", done + timeout, 0);
        chk(!dclk_en, "R1 clock off after reset", dclk_en, 0);
        chk(dram_rst == 1'b1, "R1 reset line idle", dram_rst, 1);
        chk(err_code == 3'd0, "R1 err code after reset", err_code, 0);
        chk(!(cfg_wr | cke_wr | init_wr | mr_wr | pad_rel_wr | cmd_wr), "R1 strobes after reset", 1, 0);
        run_seq(1'b0, 0, 0, 1'b0, 1'b0, 2);
        run_seq(1'b1, 1, 0, 1'b0, 1'b0, 0);
        run_seq(1'b1, 3, 0, 1'b0, 1'b1, 5);
        for (int s = 1; s <= 5; s++) run_seq(1'b1, s % 4, s, 1'b0, 1'b0, 1);
        run_seq(1'b0, 2, 5, 1'b0, 1'b0, 3);
        run_seq(1'b1, 0, 1, 1'b1, 1'b0, 0);
        for (int n = 0; n < 40; n++) begin
            r  = $urandom_range(0, 1);
            rv = $urandom_range(0, 3);
            h  = $urandom_range(0, 6);
            m  = $urandom_range(0, 1);
            st = 0;
            if ($urandom_range(0, 3) == 0) begin
                if (r != 0) st = $urandom_range(1, 5);
                else begin
                    k = $urandom_range(0, 2);
                    st = (k == 0) ? 1 : (k == 1) ? 2 : 5;
                end
            end
            run_seq(r[0], rv, st, 1'b0, m[0], h);
        end
        fin = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!fin) begin
            n_run++;
            n_fail++;
            $display("FAIL R1 watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule